// File: doc/BRIEF.md
# Pseudo-Differential Line Transmitter with Forwarded Clock

This block drives a differential-style link from ordinary single-ended output pins. It produces a true/complement data pair and a true/complement forwarded clock pair. An external resistor network then scales these to low-swing differential levels. Two related clocks come from outside the block: a bit-rate clock `clk_tx1` and a clock at twice that rate, `clk_tx2`. Their rising edges coincide on every other `clk_tx2` edge. Each output pair comes from two separate registers. One register takes the bit as it is and the other takes it through an inverter, so the two wires of a pair change on the same edge.

In direct mode, the data pair carries `line_in`, sampled once per bit period. In serial mode, core logic on its own slower clock `wr_clk` pushes narrow parallel words into a small dual-clock queue. The transmit side pops one word every four bit periods under a free-running slot counter. It sends bit 0 first and holds each bit for `4 / WORD_W` bit periods.

The forwarded clock comes from a toggle register on `clk_tx2`, which is then registered into its own pair. It is high in the first half of each bit period, so its falling edge falls in the middle of each data bit, where a receiver samples.

Top module: `pdiff_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next edge leaves `dout_p`=0, `dout_n`=1, `fclk_p`=0 and `fclk_n`=1. `wr_full` reads 0 in reset.
- R2: Outside reset, `dout_n` is always the inverse of `dout_p`, and `fclk_n` is always the inverse of `fclk_p`.
- R3: When `ser_mode`=0, the `line_in` value sampled at a `clk_tx1` rising edge appears on `dout_p` from that edge until the next one.
- R4: Once out of reset, `fclk_p` is 1 between a `clk_tx1` rising edge and the following `clk_tx2` rising edge (the mid-bit edge), and 0 for the rest of the bit period. `fclk_p` therefore changes on every `clk_tx2` rising edge.
- R5: When `ser_mode`=1, each word is sent bit 0 first. Every bit is held for 4/WORD_W bit periods, and a new word is taken only when the 2-bit slot counter wraps from 3 to 0.
- R6: The first `clk_tx1` edge that sees `ser_mode`=1 loads a word. Bit 0 of that word drives `dout_p` from the next edge on.
- R7: Words written with `wr_en`=1 at `wr_clk` rising edges are sent in the order they were written.
- R8: A load that finds the queue empty sends the all-zero idle word and removes nothing from the queue.
- R9: `wr_full` is 1 while DEPTH words (8 by default) are waiting. A write while `wr_full`=1 is dropped. `wr_full` returns to 0 once words have been sent.
- R10: Returning `ser_mode` to 0 sends `line_in` from the next edge. The next entry into serial mode loads a fresh word at once, as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx1 | input | 1 | Bit-rate transmit clock |
| clk_tx2 | input | 1 | Twice-bit-rate clock, edge aligned with clk_tx1 |
| rst_n | input | 1 | Synchronous active-low reset, seen by all three clock domains |
| ser_mode | input | 1 | 0: direct bit, 1: serialize queued words (clk_tx1 domain) |
| line_in | input | 1 | Direct-mode data bit (clk_tx1 domain) |
| wr_clk | input | 1 | Core-side write clock |
| wr_en | input | 1 | Write strobe for wr_word |
| wr_word | input | WORD_W | Parallel word to serialize |
| wr_full | output | 1 | Queue holds DEPTH words |
| dout_p | output | 1 | Data line, true |
| dout_n | output | 1 | Data line, complement |
| fclk_p | output | 1 | Forwarded clock, true |
| fclk_n | output | 1 | Forwarded clock, complement |

## Verification
A slot counter that is out of step shows up on `dout_p` inside one word time (four bit periods), as bits that are swapped, shortened or repeated. A queue pointer that is wrong makes a word appear twice, appear out of order, or go missing. It can also make `wr_full` take the wrong value on the write immediately following. A toggle register that is half a bit out of phase inverts `fclk_p` on the first bit after reset, and an independent register in a pair breaks complementarity on its first wrong edge. The bench therefore samples every bit period and both halves of the clock period, rather than only final words.

// File: rtl/pdiff_tx_pkg.sv
// Package: shared types for the pseudo-differential transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package pdiff_tx_pkg;

    // Source of the data line.
    typedef enum logic {
        LINE_DIRECT = 1'b0,
        LINE_SERIAL = 1'b1
    } line_mode_e;

    // Bit periods that each word bit is held, for a given slot count.
    function automatic int unsigned hold_periods(input int unsigned slots,
                                                 input int unsigned word_w);
        return slots / word_w;
    endfunction

endpackage

// File: rtl/pdiff_tx_pair.sv
// Module: true/complement output register pair.
// The true register takes d directly. The complement register takes d
// through an inverter, so both pins switch on the same edge.
// Assumes: rst_n is synchronous to clk.
module pdiff_tx_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic p,
    output logic n
);

    logic d_inv;
    logic p_q;
    logic n_q;

    // Inverter in front of the complement register.
    assign d_inv = ~d;

    // True register: resets low.
    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= 1'b0;
        else        p_q <= d;
    end

    // Complement register: resets high.
    always_ff @(posedge clk) begin
        if (!rst_n) n_q <= 1'b1;
        else        n_q <= d_inv;
    end

    assign p = p_q;
    assign n = n_q;

    // R1
    pair_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (p_q == 1'b0 && n_q == 1'b1));

    // R2
    pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_q != n_q);

endmodule

// File: rtl/pdiff_tx_fifo.sv
// Module: small dual-clock word queue.
// Gray-coded pointers cross each way through two-flop synchronizers.
// The read data path is combinational from the head entry.
// Assumes: AW >= 2, and rst_n is held long enough for both clocks to see it.
module pdiff_tx_fifo #(
    parameter int W  = 2,
    parameter int AW = 3
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         wr_full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_empty
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_bin, wr_bin_nx, wr_gray;
    logic [PW-1:0] rd_bin, rd_bin_nx, rd_gray;
    logic [PW-1:0] rq1, rq2;
    logic [PW-1:0] wq1, wq2;
    logic          push, pop;

    assign push      = wr_en && !wr_full;
    assign pop       = rd_en && !rd_empty;
    assign wr_bin_nx = wr_bin + PW'(push);
    assign rd_bin_nx = rd_bin + PW'(pop);

    // Write pointer, binary and Gray copies.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_bin_nx;
            wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
        end
    end

    // Storage write.
    always_ff @(posedge wr_clk) begin
        if (push) mem[wr_bin[AW-1:0]] <= wr_data;
    end

    // Read pointer brought into the write domain.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            rq1 <= '0;
            rq2 <= '0;
        end else begin
            rq1 <= rd_gray;
            rq2 <= rq1;
        end
    end

    // Read pointer, binary and Gray copies.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_bin_nx;
            rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
        end
    end

    // Write pointer brought into the read domain.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            wq1 <= '0;
            wq2 <= '0;
        end else begin
            wq1 <= wr_gray;
            wq2 <= wq1;
        end
    end

    assign wr_full  = (wr_gray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign rd_empty = (rd_gray == wq2);
    assign rd_data  = mem[rd_bin[AW-1:0]];

    // R9
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && wr_full) |=> (wr_bin == $past(wr_bin)));

    // R8
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en |-> !rd_empty);

endmodule

// File: rtl/pdiff_tx_serializer.sv
// Module: slot counter and bit mux for the data line.
// In serial mode, a word is loaded when the counter wraps to 0, and the
// top counter bits pick the bit to send, so bit 0 goes first. In direct
// mode the counter waits at its last slot, so the next entry loads at once.
// Assumes: WORD_W is a power of two no larger than 2**CNT_W.
module pdiff_tx_serializer
    import pdiff_tx_pkg::*;
#(
    parameter int              WORD_W = 2,
    parameter int              CNT_W  = 2,
    parameter logic [WORD_W-1:0] IDLE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_mode_e        mode,
    input  logic              line_in,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              fifo_pop,
    output logic              line_bit
);

    localparam int              SEL_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = '1;

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;
    logic [SEL_W-1:0]  sel;
    logic              ser_on;
    logic              load;

    assign ser_on   = (mode == LINE_SERIAL);
    assign load     = ser_on && (cnt_q == LAST);
    assign fifo_pop = load && !fifo_empty;

    // Slot counter: free-running in serial mode, parked at LAST otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= LAST;
        else if (!ser_on) cnt_q <= LAST;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // Word holding register: takes the queue head, or idle when empty.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= IDLE;
        else if (load) word_q <= fifo_empty ? IDLE : fifo_word;
    end

    assign sel      = cnt_q[CNT_W-1 -: SEL_W];
    assign line_bit = ser_on ? word_q[sel] : line_in;

    // R5
    word_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/pdiff_tx_clkfwd.sv
// Module: forwarded clock generator.
// A run flag in the bit-rate domain releases a toggle register on the
// double-rate clock. The toggle is then registered into a true/complement
// pair. The run flag changes only on edges shared by both clocks, so the
// toggle always starts on a mid-bit edge, and the output is high in the
// first half of each bit.
// Assumes: clk_2x rising edges coincide with every clk_1x rising edge.
module pdiff_tx_clkfwd (
    input  logic clk_1x,
    input  logic clk_2x,
    input  logic rst_n,
    output logic fclk_p,
    output logic fclk_n
);

    logic run_q;
    logic tog_q;
    logic run_seen_q;

    // Run flag, bit-rate domain.
    always_ff @(posedge clk_1x) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // Toggle register, held low until the run flag is seen.
    always_ff @(posedge clk_2x) begin
        if (!rst_n)      tog_q <= 1'b0;
        else if (!run_q) tog_q <= 1'b0;
        else             tog_q <= ~tog_q;
    end

    // Run flag as seen in the double-rate domain, used to qualify the check.
    always_ff @(posedge clk_2x) begin
        if (!rst_n) run_seen_q <= 1'b0;
        else        run_seen_q <= run_q;
    end

    pdiff_tx_pair u_clk_pair (
        .clk   (clk_2x),
        .rst_n (rst_n),
        .d     (tog_q),
        .p     (fclk_p),
        .n     (fclk_n)
    );

    // R4
    fclk_toggle_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (run_seen_q && $past(run_seen_q)) |-> (fclk_p != $past(fclk_p)));

endmodule

// File: rtl/pdiff_tx.sv
// Module: pseudo-differential line transmitter (top).
// Core words enter on wr_clk through a dual-clock queue. The serializer
// picks the data-line bit on clk_tx1, the data pair registers it, and
// the clock forwarder builds the clock pair on clk_tx2.
// Assumes: clk_tx1 and clk_tx2 come from one source with aligned edges,
// and ser_mode and line_in are driven from the clk_tx1 domain.
module pdiff_tx
    import pdiff_tx_pkg::*;
#(
    parameter int WORD_W = 2,
    parameter int CNT_W  = 2,
    parameter int AW     = 3
) (
    input  logic              clk_tx1,
    input  logic              clk_tx2,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              line_in,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic              wr_full,
    output logic              dout_p,
    output logic              dout_n,
    output logic              fclk_p,
    output logic              fclk_n
);

    localparam int SLOTS = 1 << CNT_W;
    localparam int HOLD  = hold_periods(SLOTS, WORD_W);

    line_mode_e        mode;
    logic              q_empty;
    logic              q_pop;
    logic [WORD_W-1:0] q_word;
    logic              line_bit;

    assign mode = line_mode_e'(ser_mode);

    pdiff_tx_fifo #(.W(WORD_W), .AW(AW)) u_queue (
        .wr_clk   (wr_clk),
        .rd_clk   (clk_tx1),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_word),
        .wr_full  (wr_full),
        .rd_en    (q_pop),
        .rd_data  (q_word),
        .rd_empty (q_empty)
    );

    pdiff_tx_serializer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ser (
        .clk        (clk_tx1),
        .rst_n      (rst_n),
        .mode       (mode),
        .line_in    (line_in),
        .fifo_empty (q_empty),
        .fifo_word  (q_word),
        .fifo_pop   (q_pop),
        .line_bit   (line_bit)
    );

    pdiff_tx_pair u_data_pair (
        .clk   (clk_tx1),
        .rst_n (rst_n),
        .d     (line_bit),
        .p     (dout_p),
        .n     (dout_n)
    );

    pdiff_tx_clkfwd u_fwd (
        .clk_1x (clk_tx1),
        .clk_2x (clk_tx2),
        .rst_n  (rst_n),
        .fclk_p (fclk_p),
        .fclk_n (fclk_n)
    );

    // Structural parameter checks at elaboration.
    initial begin
        slots_fit_chk: assert (HOLD >= 1 && HOLD * WORD_W == SLOTS);
    end

    // R3
    direct_path_chk: assert property (@(posedge clk_tx1) disable iff (!rst_n)
        (mode == LINE_DIRECT) |=> (dout_p == $past(line_in)));

endmodule

// File: tb/sim_pdiff_tx.sv
// Directed bench for pdiff_tx: one task per scenario, each checking itself.
module sim_pdiff_tx;

    logic       clk_tx1, clk_tx2, wr_clk, rst_n;
    logic       ser_mode, line_in, wr_en;
    logic [1:0] wr_word;
    logic       wr_full, dout_p, dout_n, fclk_p, fclk_n;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [1:0] exp_w [12];

    pdiff_tx u0 (
        .clk_tx1 (clk_tx1), .clk_tx2 (clk_tx2), .rst_n (rst_n),
        .ser_mode(ser_mode), .line_in (line_in), .wr_clk (wr_clk),
        .wr_en   (wr_en),    .wr_word (wr_word), .wr_full(wr_full),
        .dout_p  (dout_p),   .dout_n  (dout_n),
        .fclk_p  (fclk_p),   .fclk_n  (fclk_n)
    );

    // 50 MHz double-rate clock; the bit clock rises on every other edge of it.
    initial begin
        clk_tx2 = 0; clk_tx1 = 0;
        forever begin
            #10 clk_tx2 = 1; clk_tx1 = ~clk_tx1;
            #10 clk_tx2 = 0;
        end
    end

    // Unrelated core clock.
    initial begin
        wr_clk = 0;
        forever #13 wr_clk = ~wr_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pairs(input string req);
        check(dout_n == ~dout_p, {req, "/R2 data pair"}, dout_n, !dout_p);
        check(fclk_n == ~fclk_p, {req, "/R2 clock pair"}, fclk_n, !fclk_p);
    endtask

    task automatic push_word(input logic [1:0] w);
        @(negedge wr_clk); wr_en = 1; wr_word = w;
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic tx_wait(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_tx1);
        #1;
    endtask

    // R1: levels while reset is held.
    task automatic t_reset();
        rst_n = 0; ser_mode = 0; line_in = 1; wr_en = 0; wr_word = 0;
        tx_wait(6);
        check(dout_p == 0, "R1 dout_p", dout_p, 0);
        check(dout_n == 1, "R1 dout_n", dout_n, 1);
        check(fclk_p == 0, "R1 fclk_p", fclk_p, 0);
        check(fclk_n == 1, "R1 fclk_n", fclk_n, 1);
        check(wr_full == 0, "R1 wr_full", wr_full, 0);
        rst_n = 1; line_in = 0;
        tx_wait(3);
    endtask

    // R4: forwarded clock high in the first half, low in the second.
    task automatic t_fwd_clock();
        for (int b = 0; b < 6; b++) begin
            @(posedge clk_tx1); #1;
            check(fclk_p == 1, "R4 first half", fclk_p, 1);
            check_pairs("R4");
            @(posedge clk_tx2); #1;
            check(fclk_p == 0, "R4 second half", fclk_p, 0);
            check_pairs("R4");
        end
    endtask

    // R3: direct bit appears after one bit-clock edge.
    task automatic t_direct();
        logic [7:0] pat = 8'b1011_0010;
        @(posedge clk_tx1); #1;
        for (int i = 0; i < 8; i++) begin
            line_in = pat[i];
            @(posedge clk_tx1); #1;
            check(dout_p == pat[i], "R3 direct bit", dout_p, pat[i]);
            check_pairs("R3");
        end
    endtask

    // R5/R6/R7/R8/R10: send n words from exp_w, then return to direct mode.
    task automatic run_serial(input int n, input string req);
        line_in = 1;
        @(posedge clk_tx1); #1;
        ser_mode = 1;
        @(posedge clk_tx1); #1;  // load edge (R6)
        for (int k = 0; k < 4 * n; k++) begin
            logic e;
            @(posedge clk_tx1); #1;
            e = exp_w[k / 4][(k % 4) / 2];
            check(dout_p == e, {req, "/R5 serial bit"}, dout_p, e);
            check_pairs(req);
        end
        ser_mode = 0;
        @(posedge clk_tx1); #1;
        check(dout_p == 1, "R10 back to direct", dout_p, 1);
        line_in = 0;
    endtask

    // R7/R8: ordered words followed by an idle word.
    task automatic t_serial_order();
        push_word(2'b01); push_word(2'b10); push_word(2'b11);
        tx_wait(12);
        exp_w[0] = 2'b01; exp_w[1] = 2'b10; exp_w[2] = 2'b11; exp_w[3] = 2'b00;
        run_serial(4, "R7 order, R8 idle, R6 first load");
    endtask

    // R9: full flag, dropped write, release after draining.
    task automatic t_full();
        logic [1:0] ws [8] = '{2'b10, 2'b01, 2'b11, 2'b00, 2'b01, 2'b10, 2'b11, 2'b01};
        for (int i = 0; i < 8; i++) begin
            check(wr_full == 0, "R9 not full yet", wr_full, 0);
            push_word(ws[i]);
            exp_w[i] = ws[i];
        end
        check(wr_full == 1, "R9 full at depth", wr_full, 1);
        push_word(2'b11);
        check(wr_full == 1, "R9 still full", wr_full, 1);
        exp_w[8] = 2'b00; exp_w[9] = 2'b00;
        tx_wait(12);
        run_serial(10, "R9 dropped write, R10 re-entry");
        for (int i = 0; i < 4; i++) @(posedge wr_clk);
        #1;
        check(wr_full == 0, "R9 released", wr_full, 0);
    endtask

    initial begin
        t_reset();
        t_fwd_clock();
        t_direct();
        t_serial_order();
        t_full();
        t_direct();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule